// File: doc/BRIEF.md
# Multiplexed Serial Converter Front-End Model

This block is the device-side digital logic of an eight-input successive-approximation converter with a serial port. It is built to run in place of the real converter while a host controller is being verified. The host raises the select/convert line to start a conversion. A fixed-length internal timer models the conversion, and the block moves between acquire, convert, nap and sleep power states. Between conversions the host lowers the line. It then shifts a 7-bit setup word in on SDI and clocks the previous result out on SDO.

The setup word chooses the positive and negative inputs, the output coding and the sleep request. The block takes no analog input. The code to report is presented on a test port and is held at the start of each conversion. The block reports its power state and the decoded input pair as status outputs, so a bench can compare them with what the host intended.

All inputs are sampled on the system clock. Edges on the select line and on SCK are found by comparing each input with its value one clock earlier.

Top module: `adc_fe_top`

## Requirements
- R1: After reset the power state is acquire (code 0), the decoded pair is channel 0 against ground (ground reported as code 8), and the output coding is straight binary (uni_mode = 1).
- R2: A rising edge on cs_conv in the acquire or nap state starts a conversion. The power state reads convert (code 1) for exactly CONV_CYCLES clocks. Further rising edges during that time neither restart nor lengthen it.
- R3: sdo_en is 0 whenever cs_conv is high and throughout a conversion. sdo is 0 whenever sdo_en is 0.
- R4: If cs_conv is already low when a conversion ends, the state returns to acquire (code 0), sdo_en rises and the result MSB appears on sdo in that same clock.
- R5: If cs_conv is high when a conversion ends, the state becomes nap (code 2). It returns to acquire one clock after cs_conv goes low.
- R6: The result is shifted out MSB first. SDO advances one bit on each falling SCK edge while the port is open. Once all RES bits have been shifted out, sdo reads 0.
- R7: The setup word is shifted in on rising SCK edges, first bit first, in this order: SD, OS, S1, S0, COM, UNI, SLP. It is taken on the 7th rising edge of a frame. It is applied at the next conversion start. A frame with fewer than 7 rising edges changes nothing.
- R8: With SD=0 the inputs form a pair. The positive input is 2*{S1,S0}+OS and the negative input is the other member of the pair.
- R9: With SD=1 the positive input is {S1,S0,OS}. The negative input is ground (code 8) when COM=0 and channel 7 when COM=1.
- R10: A word with SD=0 and COM=1 is discarded, and so is a word with SD=1, COM=1 and channel 7 selected. The previous setup stays in force.
- R11: UNI=1 gives straight binary, equal to conv_value. UNI=0 gives two's complement, equal to conv_value with its MSB inverted. The UNI value used is the one in force at the conversion start, and uni_mode shows it.
- R12: A word with SLP=1 moves the block to sleep (code 3) as soon as the word is taken. In sleep, rising edges on cs_conv start no conversion. A later word with SLP=0 returns the block to acquire.
- R13: conv_value is sampled at the conversion start. Changes to it during the conversion do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_conv | input | 1 | Select/convert line: a rising edge starts a conversion, and low opens the serial port |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial setup word input |
| conv_value | input | RES | Offset-binary code that the next conversion reports |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Drive enable for sdo; 0 means high impedance |
| pwr_state | output | 2 | 0 acquire, 1 convert, 2 nap, 3 sleep |
| pos_ch | output | 4 | Positive input channel in force |
| neg_ch | output | 4 | Negative input channel in force, 8 for ground |
| uni_mode | output | 1 | 1 when the coding in force is straight binary |

## Verification
The hardest situation to reach from the ports is a short select pulse. Here cs_conv falls back low during a conversion and then rises again before the timer expires. The result must then show up on SDO in the very clock the conversion ends, with the stray edge ignored. The stimulus pulses cs_conv inside the timed window and checks the conversion length and the MSB at that first clock. The sweep walks all 64 setup words with SLP clear, invalid ones included, so that discarded words and held setups follow valid ones in every order. Sleep is entered and left on its own, with a rising edge in between.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int CH_W     = 4;
    localparam int CFG_BITS = 7;
    localparam logic [CH_W-1:0] GND_CODE = 4'd8;
    localparam logic [CH_W-1:0] COM_CH   = 4'd7;

    typedef enum logic [1:0] {
        PS_ACQ   = 2'd0,
        PS_CONV  = 2'd1,
        PS_NAP   = 2'd2,
        PS_SLEEP = 2'd3
    } pwr_e;

    // First serial bit lands in the top field.
    typedef struct packed {
        logic       se;
        logic       odd;
        logic [1:0] sel;
        logic       com;
        logic       uni;
        logic       slp;
    } cfg_t;

    typedef struct packed {
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
        logic            uni;
    } route_t;

    localparam cfg_t RESET_CFG = '{se: 1'b1, odd: 1'b0, sel: 2'b00,
                                   com: 1'b0, uni: 1'b1, slp: 1'b0};

    function automatic logic cfg_ok(input cfg_t c);
        logic ok;
        ok = 1'b1;
        if (!c.se && c.com)
            ok = 1'b0;
        if (c.se && c.com && ({c.sel, c.odd} == 3'd7))
            ok = 1'b0;
        return ok;
    endfunction

    function automatic route_t route(input cfg_t c);
        route_t r;
        r.pos = {1'b0, c.sel, c.odd};
        if (!c.se)
            r.neg = {1'b0, c.sel, ~c.odd};
        else if (c.com)
            r.neg = COM_CH;
        else
            r.neg = GND_CODE;
        r.uni = c.uni;
        return r;
    endfunction

endpackage

// File: rtl/adc_fe_cfg.sv
module adc_fe_cfg
    import adc_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_conv,
    input  logic port_open,
    input  logic sck_rise,
    input  logic sdi,
    output cfg_t pend,
    output logic word_done
);

    localparam int BW = $clog2(CFG_BITS + 1);

    logic [BW-1:0]       nbits;
    logic [CFG_BITS-1:0] shreg;
    logic [CFG_BITS-1:0] word_now;

    assign word_now = {shreg[CFG_BITS-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            nbits     <= '0;
            shreg     <= '0;
            pend      <= RESET_CFG;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (cs_conv) begin
                nbits <= '0;
            end else if (port_open && sck_rise && (nbits != BW'(CFG_BITS))) begin
                nbits <= nbits + 1'b1;
                shreg <= word_now;
                if (nbits == BW'(CFG_BITS - 1)) begin
                    if (cfg_ok(cfg_t'(word_now))) begin
                        pend      <= cfg_t'(word_now);
                        word_done <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adc_fe_ctrl.sv
module adc_fe_ctrl
    import adc_fe_pkg::*;
#(
    parameter int CONV_CYCLES = 24
)(
    input  logic clk,
    input  logic rst,
    input  logic cs_conv,
    input  logic cs_rise,
    input  logic word_done,
    input  logic slp_req,
    output pwr_e state,
    output logic start,
    output logic finish
);

    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign start  = cs_rise && ((state == PS_ACQ) || (state == PS_NAP));
    assign finish = (state == PS_CONV) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_ACQ;
            cnt   <= '0;
        end else begin
            case (state)
                PS_ACQ: begin
                    if (start) begin
                        state <= PS_CONV;
                        cnt   <= CW'(CONV_CYCLES - 1);
                    end else if (word_done && slp_req) begin
                        state <= PS_SLEEP;
                    end
                end
                PS_NAP: begin
                    if (start) begin
                        state <= PS_CONV;
                        cnt   <= CW'(CONV_CYCLES - 1);
                    end else if (!cs_conv) begin
                        state <= PS_ACQ;
                    end
                end
                PS_CONV: begin
                    if (finish)
                        state <= cs_conv ? PS_NAP : PS_ACQ;
                    else
                        cnt <= cnt - 1'b1;
                end
                PS_SLEEP: begin
                    if (word_done && !slp_req)
                        state <= PS_ACQ;
                end
                default: state <= PS_ACQ;
            endcase
        end
    end

endmodule

// File: rtl/adc_fe_out.sv
module adc_fe_out #(
    parameter int RES = 16
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           finish,
    input  logic           uni,
    input  logic           shift,
    input  logic [RES-1:0] conv_value,
    output logic           out_bit
);

    localparam logic [RES-1:0] MSB_MASK = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] held;
    logic [RES-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            out_sr <= '0;
        end else begin
            if (start)
                held <= uni ? conv_value : (conv_value ^ MSB_MASK);
            if (finish)
                out_sr <= held;
            else if (shift)
                out_sr <= {out_sr[RES-2:0], 1'b0};
        end
    end

    assign out_bit = out_sr[RES-1];

endmodule

// File: rtl/adc_fe_top.sv
module adc_fe_top
    import adc_fe_pkg::*;
#(
    parameter int RES         = 16,
    parameter int CONV_CYCLES = 24
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_conv,
    input  logic            sck,
    input  logic            sdi,
    input  logic [RES-1:0]  conv_value,
    output logic            sdo,
    output logic            sdo_en,
    output logic [1:0]      pwr_state,
    output logic [CH_W-1:0] pos_ch,
    output logic [CH_W-1:0] neg_ch,
    output logic            uni_mode
);

    logic   cs_q;
    logic   sck_q;
    logic   cs_rise;
    logic   sck_rise;
    logic   sck_fall;
    logic   port_open;
    logic   word_done;
    logic   start;
    logic   finish;
    logic   out_bit;
    cfg_t   pend;
    pwr_e   state;
    route_t act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            act   <= route(RESET_CFG);
        end else begin
            cs_q  <= cs_conv;
            sck_q <= sck;
            if (start)
                act <= route(pend);
        end
    end

    assign cs_rise   = cs_conv & ~cs_q;
    assign sck_rise  = sck & ~sck_q;
    assign sck_fall  = ~sck & sck_q;
    assign port_open = ~cs_conv && (state != PS_CONV);

    adc_fe_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cs_conv   (cs_conv),
        .port_open (port_open),
        .sck_rise  (sck_rise),
        .sdi       (sdi),
        .pend      (pend),
        .word_done (word_done)
    );

    adc_fe_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_conv   (cs_conv),
        .cs_rise   (cs_rise),
        .word_done (word_done),
        .slp_req   (pend.slp),
        .state     (state),
        .start     (start),
        .finish    (finish)
    );

    adc_fe_out #(.RES(RES)) u_out (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .finish     (finish),
        .uni        (pend.uni),
        .shift      (port_open && sck_fall),
        .conv_value (conv_value),
        .out_bit    (out_bit)
    );

    assign sdo_en    = port_open;
    assign sdo       = port_open & out_bit;
    assign pwr_state = state;
    assign pos_ch    = act.pos;
    assign neg_ch    = act.neg;
    assign uni_mode  = act.uni;

endmodule

// File: rtl/adc_fe_chk.sv
module adc_fe_chk
    import adc_fe_pkg::*;
#(
    parameter int CONV_CYCLES = 24
)(
    input logic            clk,
    input logic            rst,
    input logic            cs_conv,
    input logic            sdo_en,
    input logic [1:0]      pwr_state,
    input logic [CH_W-1:0] pos_ch,
    input logic [CH_W-1:0] neg_ch
);

    localparam int RW = $clog2(CONV_CYCLES + 1) + 1;

    logic [RW-1:0] run;
    logic          in_conv;
    logic          in_nap;
    logic          in_sleep;

    assign in_conv  = (pwr_state == 2'd1);
    assign in_nap   = (pwr_state == 2'd2);
    assign in_sleep = (pwr_state == 2'd3);

    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (in_conv)
            run <= run + 1'b1;
        else
            run <= '0;
    end

    assert_hiz_high_R3: assert property (@(posedge clk) disable iff (rst)
        cs_conv |-> !sdo_en);

    assert_hiz_conv_R3: assert property (@(posedge clk) disable iff (rst)
        in_conv |-> !sdo_en);

    assert_conv_bound_R2: assert property (@(posedge clk) disable iff (rst)
        in_conv |-> (run < RW'(CONV_CYCLES)));

    assert_conv_len_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(in_conv) && !in_conv) |-> ($past(run) == RW'(CONV_CYCLES - 1)));

    assert_route_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$rose(in_conv) |-> ($stable(pos_ch) && $stable(neg_ch)));

    assert_nap_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (in_nap && !cs_conv) |=> (pwr_state == 2'd0));

    assert_sleep_no_conv_R12: assert property (@(posedge clk) disable iff (rst)
        in_sleep |=> !in_conv);

    assert_pair_distinct_R10: assert property (@(posedge clk) disable iff (rst)
        pos_ch != neg_ch);

endmodule

bind adc_fe_top adc_fe_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_conv   (cs_conv),
    .sdo_en    (sdo_en),
    .pwr_state (pwr_state),
    .pos_ch    (pos_ch),
    .neg_ch    (neg_ch)
);

// File: tb/sim_adc_fe_top.sv
module sim_adc_fe_top;

    localparam int RES  = 16;
    localparam int CONV = 24;
    localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cs_conv = 1'b1;
    logic           sck = 1'b0;
    logic           sdi = 1'b0;
    logic [RES-1:0] conv_value = '0;
    logic           sdo;
    logic           sdo_en;
    logic [1:0]     pwr_state;
    logic [3:0]     pos_ch;
    logic [3:0]     neg_ch;
    logic           uni_mode;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_fe_top #(.RES(RES), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst(rst), .cs_conv(cs_conv), .sck(sck), .sdi(sdi),
        .conv_value(conv_value), .sdo(sdo), .sdo_en(sdo_en),
        .pwr_state(pwr_state), .pos_ch(pos_ch), .neg_ch(neg_ch),
        .uni_mode(uni_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Word bits: [6]SD [5]OS [4]S1 [3]S0 [2]COM [1]UNI [0]SLP
    function automatic bit w_ok(input logic [6:0] w);
        int p;
        p = 2 * int'(w[4:3]) + int'(w[5]);
        if (!w[6] && w[2]) return 0;
        if (w[6] && w[2] && p == 7) return 0;
        return 1;
    endfunction

    function automatic int w_pos(input logic [6:0] w);
        return 2 * int'(w[4:3]) + int'(w[5]);
    endfunction

    function automatic int w_neg(input logic [6:0] w);
        if (!w[6]) return 2 * int'(w[4:3]) + (1 - int'(w[5]));
        return w[2] ? 7 : 8;
    endfunction

    task automatic xfer(input logic [6:0] w, input int nedges, output logic [RES-1:0] rd);
        for (int i = 0; i < nedges; i++) begin
            if (i < RES) rd[RES-1-i] = sdo;
            sdi = (i < 7) ? w[6-i] : 1'b0;
            sck = 1'b1;
            tick(2);
            sck = 1'b0;
            tick(2);
        end
        sdi = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0]     pend;
        logic [6:0]     w;
        logic [RES-1:0] rd;
        logic [RES-1:0] v;
        logic [RES-1:0] expr;
        bit             have;
        int             n;
        string          tag;

        pend = 7'b1000010;
        have = 0;
        expr = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check(pwr_state == 2'd0, "R1 state", pwr_state, 0);
        check(pos_ch == 4'd0, "R1 pos", pos_ch, 0);
        check(neg_ch == 4'd8, "R1 neg", neg_ch, 8);
        check(uni_mode == 1'b1, "R1 uni", uni_mode, 1);
        check(sdo_en == 1'b0, "R3 high", sdo_en, 0);

        cs_conv = 1'b0;
        tick(1);
        for (int k = 0; k < 64; k++) begin
            w = {k[5:0], 1'b0};
            xfer(w, RES, rd);
            if (have)
                check(rd == expr, "R6 R11 R13 result", int'(rd), int'(expr));
            if (w_ok(w)) pend = w;
            v = RES'(k * 40503 + 4951);
            conv_value = v;
            cs_conv = 1'b1;
            tick(1);
            check(pwr_state == 2'd1, "R2 start", pwr_state, 1);
            tag = !w_ok(w) ? "R10 hold" : (pend[6] ? "R9 single" : "R8 pair");
            check(pos_ch == 4'(w_pos(pend)), tag, pos_ch, w_pos(pend));
            check(neg_ch == 4'(w_neg(pend)), tag, neg_ch, w_neg(pend));
            check(uni_mode == pend[1], "R11 mode", uni_mode, pend[1]);
            conv_value = ~v;
            n = 0;
            while (pwr_state == 2'd1 && n < 1000) begin
                n++;
                tick(1);
            end
            check(n == CONV, "R2 length", n, CONV);
            check(pwr_state == 2'd2, "R5 nap", pwr_state, 2);
            check(sdo_en == 1'b0, "R3 nap hiz", sdo_en, 0);
            expr = pend[1] ? v : (v ^ MSB);
            cs_conv = 1'b0;
            tick(1);
            check(pwr_state == 2'd0, "R5 wake", pwr_state, 0);
            check(sdo == expr[RES-1], "R6 msb", sdo, expr[RES-1]);
            have = 1;
        end

        // R12 sleep entry and exit
        xfer(7'b1000011, RES, rd);
        check(rd == expr, "R11 last result", int'(rd), int'(expr));
        pend = 7'b1000011;
        tick(2);
        check(pwr_state == 2'd3, "R12 sleep", pwr_state, 3);
        cs_conv = 1'b1;
        tick(4);
        check(pwr_state == 2'd3, "R12 edge ignored", pwr_state, 3);
        check(sdo_en == 1'b0, "R3 sleep hiz", sdo_en, 0);
        cs_conv = 1'b0;
        tick(1);
        xfer(7'b1000010, 7, rd);
        pend = 7'b1000010;
        tick(2);
        check(pwr_state == 2'd0, "R12 wake", pwr_state, 0);

        // R7 short frame leaves setup alone
        xfer(7'b0110010, 3, rd);
        conv_value = 16'h1234;
        cs_conv = 1'b1;
        tick(1);
        check(pos_ch == 4'd0, "R7 short frame pos", pos_ch, 0);
        check(neg_ch == 4'd8, "R7 short frame neg", neg_ch, 8);
        tick(CONV + 2);
        check(pwr_state == 2'd2, "R5 nap again", pwr_state, 2);

        // R4 short pulse, stray rising edge during conversion
        cs_conv = 1'b0;
        tick(1);
        v = 16'hA5C3;
        conv_value = v;
        cs_conv = 1'b1;
        tick(1);
        cs_conv = 1'b0;
        n = 0;
        while (pwr_state == 2'd1 && n < 1000) begin
            n++;
            if (n == 3) cs_conv = 1'b1;
            if (n == 5) cs_conv = 1'b0;
            if (n == 8) check(sdo_en == 1'b0, "R3 conv hiz", sdo_en, 0);
            tick(1);
        end
        check(n == CONV, "R2 stray edge", n, CONV);
        check(pwr_state == 2'd0, "R4 active", pwr_state, 0);
        check(sdo_en == 1'b1, "R4 enable", sdo_en, 1);
        check(sdo == v[RES-1], "R4 msb", sdo, v[RES-1]);
        xfer(7'b1000010, RES, rd);
        check(rd == v, "R4 R6 result", int'(rd), int'(v));
        check(sdo == 1'b0, "R6 drained", sdo, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule